// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit with Guarded Accumulators

This block is a signed fractional multiply-accumulate datapath for a fixed-point signal processor. Two 24-bit operands in the range -1 to just under +1 are multiplied in one cycle. The product is aligned so that its binary point matches the accumulator, and it is then added to or subtracted from one of two 56-bit accumulators. Each accumulator holds 8 guard bits above a 48-bit fraction. Partial sums can therefore grow past ±1 without any loss, as long as they come back into range before they are read.

Before the product is added, the old accumulator value passes through a scaler. The scaler can double it, halve it (arithmetic), pass it unchanged or replace it with zero. A load operation writes an accumulator directly from the two operands joined into one 48-bit word, with the sign extended into the guard bits.

Reading is combinational. The selected accumulator is reduced to a 24-bit word, either by truncation or by round-half-to-even. If the value does not fit a 24-bit fraction, a limiter substitutes the nearest full-scale constant. Each accumulator reports whether its guard bits are in use. A sticky flag records that a read marked as a real transfer was limited.

Top module: `frac_mac`

## Requirements
- R1: After reset both accumulators hold zero, `rd_full` and `rd_word` are zero, `ext_flags` is 0 and `lim_sticky` is 0.
- R2: `op_code` 1 (multiply-accumulate) writes scaled(old) + P into accumulator `op_acc`, visible after the next rising edge. P is the 48-bit signed product of `opnd_x` and `opnd_y`, sign-extended to 56 bits and then shifted left by one.
- R3: `op_code` 2 (multiply-subtract) writes scaled(old) - P into accumulator `op_acc`.
- R4: `scale_mode` sets the scaled old value: 0 passes it unchanged, 1 shifts it left by one bit, 2 shifts it right by one bit with sign fill, and 3 replaces it with zero.
- R5: `op_code` 3 (load) writes {8 copies of opnd_x[23], opnd_x, opnd_y} into accumulator `op_acc`.
- R6: `op_code` 0 changes no accumulator, and an operation changes only the accumulator that `op_acc` selects.
- R7: (-1) × (-1) accumulates +1.0 exactly (0x00_800000_000000), with no wrap to -1.
- R8: `ext_flags[i]` is 1 exactly when bits 55 down to 47 of accumulator i are not all equal.
- R9: When the value read from the accumulator needs the guard bits, `rd_word` is 0x7FFFFF if the value is positive and 0x800000 if it is negative. Otherwise `rd_word` is bits 47:24 of that value.
- R10: With `rd_round`=0 the value read is the accumulator itself (truncation). With `rd_round`=1 the rounder adds 0x800000. If the low 24 bits were exactly 0x800000, bit 24 of the sum is then cleared, so that a tie rounds to an even high word.
- R11: `lim_sticky` becomes 1 after an edge at which `rd_en`=1 and the readout was limited. It stays 1 until an edge at which `lim_clr`=1 and no new limited read occurs; setting takes priority over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 2 | 0 none, 1 multiply-add, 2 multiply-subtract, 3 load |
| op_acc | input | 1 | Accumulator written (0 = A, 1 = B) |
| scale_mode | input | 2 | Treatment of the old value: 0 pass, 1 left, 2 right, 3 zero |
| opnd_x | input | 24 | First operand, high word for load |
| opnd_y | input | 24 | Second operand, low word for load |
| rd_sel | input | 1 | Accumulator read out |
| rd_round | input | 1 | 1 rounds the readout, 0 truncates it |
| rd_en | input | 1 | Marks the readout as a transfer for the sticky flag |
| lim_clr | input | 1 | Clears the sticky limit flag |
| rd_word | output | 24 | Limited 24-bit readout |
| rd_full | output | 56 | Full value of the selected accumulator |
| ext_flags | output | 2 | Guard-bits-in-use flag per accumulator |
| lim_sticky | output | 1 | Sticky limit flag |

## Verification
The bench targets the product (-1)×(-1). A design that shifts the product inside 48 bits would turn it into -1 instead of +1. It checks negative saturation with a value of -2, where a missing limiter would return 0x000000 rather than 0x800000. It also drives rounding ties with both even and odd high words and with negative values, which exposes a rounder that always rounds up. Finally, it checks that reads without `rd_en` leave the sticky flag alone, and that operations on one accumulator and no-operation cycles leave the other accumulator intact.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_MACC = 2'd1,
      OP_MSUB = 2'd2,
      OP_LOAD = 2'd3
   } mac_op_e;

   typedef enum logic [1:0] {
      SC_PASS  = 2'd0,
      SC_LEFT  = 2'd1,
      SC_RIGHT = 2'd2,
      SC_ZERO  = 2'd3
   } scale_e;
endpackage

// File: rtl/frac_mac_mult.sv
module frac_mac_mult #(
   parameter int DW = 24,
   parameter int EW = 8
) (
   input  logic signed [DW-1:0]     mul_a,
   input  logic signed [DW-1:0]     mul_b,
   output logic [EW+2*DW-1:0]       prod_al
);
   localparam int PW = 2*DW;
   localparam int AW = EW + PW;

   logic signed [PW-1:0] raw;
   logic [AW-1:0]        wide;

   assign raw     = mul_a * mul_b;
   // widen first, then drop the redundant sign bit, so +1.0 survives
   assign wide    = {{EW{raw[PW-1]}}, raw};
   assign prod_al = {wide[AW-2:0], 1'b0};
endmodule

// File: rtl/frac_mac_scaler.sv
module frac_mac_scaler
   import frac_mac_pkg::*;
#(
   parameter int AW = 56
) (
   input  logic [AW-1:0] old_val,
   input  logic [1:0]    mode,
   output logic [AW-1:0] scaled
);
   always_comb begin
      unique case (scale_e'(mode))
         SC_LEFT:  scaled = {old_val[AW-2:0], 1'b0};
         SC_RIGHT: scaled = {old_val[AW-1], old_val[AW-1:1]};
         SC_ZERO:  scaled = '0;
         default:  scaled = old_val;
      endcase
   end
endmodule

// File: rtl/frac_mac_readout.sv
module frac_mac_readout #(
   parameter int DW         = 24,
   parameter int EW         = 8,
   parameter bit CONVERGENT = 1'b1
) (
   input  logic [EW+2*DW-1:0] acc_in,
   input  logic               do_round,
   output logic [DW-1:0]      word_out,
   output logic               limited
);
   localparam int AW = EW + 2*DW;
   localparam logic [AW-1:0] HALF = AW'(1) << (DW-1);
   localparam logic [DW-1:0] POS_FS = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] NEG_FS = {1'b1, {(DW-1){1'b0}}};

   logic [AW-1:0] bumped;
   logic [AW-1:0] rounded;
   logic [AW-1:0] picked;
   logic [EW:0]   guard;

   assign bumped = acc_in + HALF;

   generate
      if (CONVERGENT) begin : g_even
         logic tie;
         assign tie     = (acc_in[DW-1:0] == HALF[DW-1:0]);
         assign rounded = tie ? {bumped[AW-1:DW+1], 1'b0, bumped[DW-1:0]} : bumped;
      end else begin : g_up
         assign rounded = bumped;
      end
   endgenerate

   assign picked   = do_round ? rounded : acc_in;
   assign guard    = picked[AW-1:2*DW-1];
   assign limited  = !((&guard) || !(|guard));
   assign word_out = limited ? (picked[AW-1] ? NEG_FS : POS_FS) : picked[2*DW-1:DW];
endmodule

// File: rtl/frac_mac.sv
module frac_mac
   import frac_mac_pkg::*;
#(
   parameter int DW         = 24,
   parameter int EW         = 8,
   parameter int NACC       = 2,
   parameter bit CONVERGENT = 1'b1,
   localparam int AW        = EW + 2*DW,
   localparam int SW        = (NACC > 1) ? $clog2(NACC) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      op_code,
   input  logic [SW-1:0]   op_acc,
   input  logic [1:0]      scale_mode,
   input  logic [DW-1:0]   opnd_x,
   input  logic [DW-1:0]   opnd_y,
   input  logic [SW-1:0]   rd_sel,
   input  logic            rd_round,
   input  logic            rd_en,
   input  logic            lim_clr,
   output logic [DW-1:0]   rd_word,
   output logic [AW-1:0]   rd_full,
   output logic [NACC-1:0] ext_flags,
   output logic            lim_sticky
);
   generate
      if (DW < 2)   begin : g_bad_dw   $error("frac_mac: DW must be at least 2");   end
      if (EW < 1)   begin : g_bad_ew   $error("frac_mac: EW must be at least 1");   end
      if (NACC < 1) begin : g_bad_nacc $error("frac_mac: NACC must be at least 1"); end
   endgenerate

   logic [NACC-1:0][AW-1:0] accs;
   logic [AW-1:0]           cur_val;
   logic [AW-1:0]           scaled;
   logic [AW-1:0]           prod;
   logic [AW-1:0]           next_val;
   logic                    rd_limited;

   assign cur_val = accs[op_acc];

   frac_mac_mult #(.DW(DW), .EW(EW)) i_mult (
      .mul_a   (opnd_x),
      .mul_b   (opnd_y),
      .prod_al (prod)
   );

   frac_mac_scaler #(.AW(AW)) i_scaler (
      .old_val (cur_val),
      .mode    (scale_mode),
      .scaled  (scaled)
   );

   always_comb begin
      unique case (mac_op_e'(op_code))
         OP_MACC: next_val = scaled + prod;
         OP_MSUB: next_val = scaled - prod;
         OP_LOAD: next_val = {{EW{opnd_x[DW-1]}}, opnd_x, opnd_y};
         default: next_val = cur_val;
      endcase
   end

   generate
      for (genvar g = 0; g < NACC; g++) begin : g_acc
         always_ff @(posedge clk) begin
            if (!rst_n)
               accs[g] <= '0;
            else if (op_code != OP_NONE && op_acc == SW'(g))
               accs[g] <= next_val;
         end
         assign ext_flags[g] = !((&accs[g][AW-1:2*DW-1]) || !(|accs[g][AW-1:2*DW-1]));
      end
   endgenerate

   assign rd_full = accs[rd_sel];

   frac_mac_readout #(.DW(DW), .EW(EW), .CONVERGENT(CONVERGENT)) i_readout (
      .acc_in   (rd_full),
      .do_round (rd_round),
      .word_out (rd_word),
      .limited  (rd_limited)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         lim_sticky <= 1'b0;
      else if (rd_en && rd_limited)
         lim_sticky <= 1'b1;
      else if (lim_clr)
         lim_sticky <= 1'b0;
   end
endmodule

// File: rtl/frac_mac_chk.sv
module frac_mac_chk #(
   parameter int DW   = 24,
   parameter int EW   = 8,
   parameter int NACC = 2,
   localparam int AW  = EW + 2*DW,
   localparam int SW  = (NACC > 1) ? $clog2(NACC) : 1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [1:0]              op_code,
   input logic [SW-1:0]           op_acc,
   input logic [1:0]              scale_mode,
   input logic [DW-1:0]           opnd_x,
   input logic [DW-1:0]           opnd_y,
   input logic [SW-1:0]           rd_sel,
   input logic                    rd_round,
   input logic                    rd_en,
   input logic                    lim_clr,
   input logic [DW-1:0]           rd_word,
   input logic [NACC-1:0]         ext_flags,
   input logic                    lim_sticky,
   input logic [NACC-1:0][AW-1:0] accs
);
   generate
      for (genvar g = 0; g < NACC; g++) begin : g_hold
         p_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (op_code == 2'd0 || op_acc != SW'(g)) |=> $stable(accs[g]));
      end
   endgenerate

   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 2'd3) |=>
      accs[$past(op_acc)] == {{EW{$past(opnd_x[DW-1])}}, $past(opnd_x), $past(opnd_y)});

   p_zero_scale_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 2'd1 && scale_mode == 2'd3 && opnd_x == '0) |=> accs[$past(op_acc)] == '0);

   p_limit_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_flags[rd_sel] && !rd_round) |->
      (rd_word == {1'b0, {(DW-1){1'b1}}} || rd_word == {1'b1, {(DW-1){1'b0}}}));

   p_sticky_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_round && ext_flags[rd_sel]) |=> lim_sticky);

   p_sticky_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_sticky && !lim_clr) |=> lim_sticky);
endmodule

bind frac_mac frac_mac_chk #(.DW(DW), .EW(EW), .NACC(NACC)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_code    (op_code),
   .op_acc     (op_acc),
   .scale_mode (scale_mode),
   .opnd_x     (opnd_x),
   .opnd_y     (opnd_y),
   .rd_sel     (rd_sel),
   .rd_round   (rd_round),
   .rd_en      (rd_en),
   .lim_clr    (lim_clr),
   .rd_word    (rd_word),
   .ext_flags  (ext_flags),
   .lim_sticky (lim_sticky),
   .accs       (accs)
);

// File: tb/test_frac_mac.sv
module test_frac_mac;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 12;

   // {op[2], acc[1], scale[2], x[24], y[24], expected accumulator[56]}
   localparam logic [108:0] VEC [NVEC] = '{
      {2'd3, 1'b0, 2'd0, 24'h123456, 24'h789ABC, 56'h00123456789ABC},
      {2'd1, 1'b0, 2'd0, 24'h400000, 24'h400000, 56'h00323456789ABC},
      {2'd1, 1'b0, 2'd3, 24'h400000, 24'h200000, 56'h00100000000000},
      {2'd2, 1'b0, 2'd0, 24'h400000, 24'h400000, 56'hFFF00000000000},
      {2'd1, 1'b0, 2'd2, 24'h000000, 24'h000000, 56'hFFF80000000000},
      {2'd1, 1'b0, 2'd1, 24'h000000, 24'h000000, 56'hFFF00000000000},
      {2'd3, 1'b0, 2'd0, 24'h800000, 24'h000000, 56'hFF800000000000},
      {2'd1, 1'b0, 2'd0, 24'h800000, 24'h400000, 56'hFF400000000000},
      {2'd1, 1'b0, 2'd3, 24'h800000, 24'h800000, 56'h00800000000000},
      {2'd1, 1'b0, 2'd1, 24'h000000, 24'h000000, 56'h01000000000000},
      {2'd1, 1'b1, 2'd3, 24'h7FFFFF, 24'h7FFFFF, 56'h007FFFFE000002},
      {2'd2, 1'b1, 2'd3, 24'h000001, 24'h000001, 56'hFFFFFFFFFFFFFE}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op_code = '0;
   logic        op_acc = 1'b0;
   logic [1:0]  scale_mode = '0;
   logic [23:0] opnd_x = '0;
   logic [23:0] opnd_y = '0;
   logic        rd_sel = 1'b0;
   logic        rd_round = 1'b0;
   logic        rd_en = 1'b0;
   logic        lim_clr = 1'b0;
   logic [23:0] rd_word;
   logic [55:0] rd_full;
   logic [1:0]  ext_flags;
   logic        lim_sticky;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frac_mac i_frac_mac (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_acc(op_acc),
      .scale_mode(scale_mode), .opnd_x(opnd_x), .opnd_y(opnd_y),
      .rd_sel(rd_sel), .rd_round(rd_round), .rd_en(rd_en), .lim_clr(lim_clr),
      .rd_word(rd_word), .rd_full(rd_full), .ext_flags(ext_flags),
      .lim_sticky(lim_sticky)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one operation at a falling edge, let it commit, then point the read port at it
   task automatic do_op(input logic [1:0] op, input logic acc, input logic [1:0] sc,
                        input logic [23:0] x, input logic [23:0] y);
      @(negedge clk);
      op_code = op; op_acc = acc; scale_mode = sc; opnd_x = x; opnd_y = y;
      @(negedge clk);
      op_code = 2'd0; rd_sel = acc;
      #1;
   endtask

   task automatic read_word(input logic sel, input logic rnd, input logic [23:0] exp, input string req);
      rd_sel = sel; rd_round = rnd;
      #1;
      check(req, 64'(rd_word), 64'(exp));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 acc A", 64'(i_frac_mac.rd_full), 64'h0);
      rd_sel = 1'b1; #1;
      check("R1 acc B", 64'(rd_full), 64'h0);
      check("R1 word", 64'(rd_word), 64'h0);
      check("R1 ext", 64'(ext_flags), 64'h0);
      check("R1 sticky", 64'(lim_sticky), 64'h0);
      rst_n = 1'b1;

      // table walk: R2 R3 R4 R5 R7
      for (int i = 0; i < NVEC; i++) begin
         do_op(VEC[i][108:107], VEC[i][106], VEC[i][105:104], VEC[i][103:80], VEC[i][79:56]);
         check($sformatf("R2 R3 R4 R5 R7 vector %0d", i), 64'(rd_full), 64'(VEC[i][55:0]));
      end

      // R6: B operations left A alone
      rd_sel = 1'b0; #1;
      check("R6 A kept", 64'(rd_full), 64'h01000000000000);
      // R8: A uses guard bits, B does not
      check("R8 ext flags", 64'(ext_flags), 64'h1);
      // R9 R7: +2.0 reads as positive full scale
      read_word(1'b0, 1'b0, 24'h7FFFFF, "R9 positive limit");

      // R6: op_code 0 with live operands changes nothing
      do_op(2'd0, 1'b0, 2'd3, 24'h555555, 24'h333333);
      check("R6 no-op", 64'(rd_full), 64'h01000000000000);

      // R9 negative side: -1.0 fits, -2.0 saturates
      do_op(2'd2, 1'b0, 2'd3, 24'h800000, 24'h800000);
      check("R3 minus one", 64'(rd_full), 64'hFF800000000000);
      check("R8 minus one not ext", 64'(ext_flags[0]), 64'h0);
      read_word(1'b0, 1'b0, 24'h800000, "R9 minus one word");
      do_op(2'd1, 1'b0, 2'd1, 24'h0, 24'h0);
      check("R8 minus two ext", 64'(ext_flags[0]), 64'h1);
      read_word(1'b0, 1'b0, 24'h800000, "R9 negative limit");

      // R10 rounding on B
      do_op(2'd3, 1'b1, 2'd0, 24'h000010, 24'h800000);
      read_word(1'b1, 1'b1, 24'h000010, "R10 tie even stays");
      read_word(1'b1, 1'b0, 24'h000010, "R10 truncate");
      do_op(2'd3, 1'b1, 2'd0, 24'h000011, 24'h800000);
      read_word(1'b1, 1'b1, 24'h000012, "R10 tie odd up");
      read_word(1'b1, 1'b0, 24'h000011, "R10 truncate odd");
      do_op(2'd3, 1'b1, 2'd0, 24'h000010, 24'h800001);
      read_word(1'b1, 1'b1, 24'h000011, "R10 above half");
      do_op(2'd3, 1'b1, 2'd0, 24'h000010, 24'h7FFFFF);
      read_word(1'b1, 1'b1, 24'h000010, "R10 below half");
      do_op(2'd3, 1'b1, 2'd0, 24'hFFFFFF, 24'h800000);
      read_word(1'b1, 1'b1, 24'h000000, "R10 negative tie");
      do_op(2'd3, 1'b1, 2'd0, 24'h7FFFFF, 24'hFFFFFF);
      check("R8 max fits", 64'(ext_flags[1]), 64'h0);
      read_word(1'b1, 1'b0, 24'h7FFFFF, "R10 max truncated");
      read_word(1'b1, 1'b1, 24'h7FFFFF, "R9 R10 rounding overflow limited");

      // R11 sticky flag: A holds -2.0
      rd_sel = 1'b0; rd_round = 1'b0; rd_en = 1'b0;
      @(negedge clk); #1;
      check("R11 no transfer no set", 64'(lim_sticky), 64'h0);
      rd_en = 1'b1;
      @(negedge clk); #1;
      check("R11 set", 64'(lim_sticky), 64'h1);
      rd_sel = 1'b1; rd_round = 1'b0;
      @(negedge clk); #1;
      check("R11 holds", 64'(lim_sticky), 64'h1);
      rd_en = 1'b0; lim_clr = 1'b1;
      @(negedge clk); #1;
      lim_clr = 1'b0;
      check("R11 cleared", 64'(lim_sticky), 64'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule